// File: doc/BRIEF.md
# Host Data Word Pixel Extractor

This block sits between a host write path and a drawing pipeline. The host delivers a 64-bit data word. The block hands out pixels from that word one at a time, each time the pipeline asks for one. Every pixel is cut from the word at a shift position and masked to the host pixel depth. In packed mode, successive requests walk down through the word, one pixel size at a time. In non-packed mode, one request consumes the whole word.

Before the pixel leaves the block, a selector can change its colour depth. Widening a field repeats the field's upper bits into the new low bits. Narrowing a field keeps its upper bits. After the depth change, an optional stage reverses the byte order of the 32-bit result. The mode inputs are captured together with the word, so they cannot change in the middle of a word.

Top module: `hostpix_extract`

## Requirements
- R1: After synchronous reset `empty_o` is 1, `pix_valid_o` is 0 and `pix_o` is 0.
- R2: A cycle with `load_i` high captures `word_i` and the mode inputs (depth, packed, double, conversion code, swap). From the next cycle `empty_o` is 0 and the extraction position is restarted, even when the previous word was only partly used. A request in the same cycle as a load is ignored.
- R3: Depth code 0, 1, 2, 3 gives a pixel size of 4, 8, 12, 32 bits. The first pixel is taken from bits [63 : 64 - size] of the word, right-aligned and zero-extended to 32 bits.
- R4: With packed mode off, one accepted request makes `empty_o` 1 on the next cycle.
- R5: With packed on and double off, each request moves the position down by one pixel size. The word is used up once the next position would fall below bit 32. This gives 8, 4, 2 or 1 pixels for depth codes 0..3.
- R6: With packed and double both on, stepping continues while the next position stays at or above 0. This gives 16, 8, 5 or 2 pixels for depth codes 0..3.
- R7: An accepted request (`req_i` high, `empty_o` low, no load) gives `pix_valid_o` high for exactly the next cycle, with the pixel on `pix_o`. In every other cycle `pix_valid_o` is 0 and `pix_o` holds its last value.
- R8: A request while `empty_o` is 1 produces no pixel and leaves the block empty.
- R9: Colour formats hold red, green and blue fields from bit 0 upward, with these widths. Format 4 uses 1, 2 and 1 bits. Format 8 uses 3, 3 and 2 bits. Format 12 uses 4, 4 and 4 bits. Format 24/32 uses 8, 8 and 8 bits in bits 23:0. Conversion code c has source format c/4 and destination format c%4, where format index 0, 1, 2, 3 means 4, 8, 12, 24/32. Widening repeats each field's bits from the top into the new low bits. Narrowing keeps each field's upper bits. Bits above the destination are 0.
- R10: Conversion codes 0, 5, 10 and 15 pass the masked pixel through unchanged.
- R11: With swap captured as 1, the converted 32-bit pixel has its bytes reversed (byte 0 ↔ 3, 1 ↔ 2) after conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures a new word and its mode |
| word_i | input | 64 | Host data word |
| depth_i | input | 2 | Host pixel depth code |
| packed_i | input | 1 | Several pixels per word |
| dbl_i | input | 1 | Double mode: step through the lower half as well |
| conv_i | input | 4 | Depth conversion code |
| swap_i | input | 1 | Byte-reverse the converted pixel |
| req_i | input | 1 | Pixel request from the pipeline |
| pix_o | output | 32 | Extracted pixel |
| pix_valid_o | output | 1 | `pix_o` carries a new pixel |
| empty_o | output | 1 | No pixel left in the current word |

## Verification
The bench walks every depth code through packed, packed-double and non-packed words and counts the pixels each one yields. A stepping rule with an off-by-one at the 32-bit or zero boundary shows up as an extra or missing pixel, most visibly at 12 bits, where the step does not divide the word. All sixteen conversion codes are driven with patterns whose fields differ from top to bottom. This exposes replication taken from the wrong end, a misplaced field, and pass-through codes that convert anyway. Swap is combined with widening conversions, so a swap placed before the conversion gives a different value. A reload in the middle of a word, and a request in the same cycle as a load, confirm that the position restarts and that the colliding request is dropped.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

  localparam int WORD_W = 64;
  localparam int PIX_W  = 32;
  localparam int CH_N   = 3;

  typedef struct packed {
    logic [1:0] depth;
    logic       pk;
    logic       dbl;
    logic [3:0] conv;
    logic       swap;
  } mode_t;

  // pixel size in bits for a depth code
  function automatic logic [6:0] pix_size(input logic [1:0] d);
    case (d)
      2'd0:    pix_size = 7'd4;
      2'd1:    pix_size = 7'd8;
      2'd2:    pix_size = 7'd12;
      default: pix_size = 7'd32;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] pix_mask(input logic [1:0] d);
    case (d)
      2'd0:    pix_mask = 32'h0000_000F;
      2'd1:    pix_mask = 32'h0000_00FF;
      2'd2:    pix_mask = 32'h0000_0FFF;
      default: pix_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // field width per colour format and channel (0 red, 1 green, 2 blue)
  function automatic logic [3:0] fld_w(input logic [1:0] fmt, input logic [1:0] ch);
    case (fmt)
      2'd0:    fld_w = (ch == 2'd1) ? 4'd2 : 4'd1;
      2'd1:    fld_w = (ch == 2'd2) ? 4'd2 : 4'd3;
      2'd2:    fld_w = 4'd4;
      default: fld_w = 4'd8;
    endcase
  endfunction

  function automatic logic [4:0] fld_p(input logic [1:0] fmt, input logic [1:0] ch);
    case (fmt)
      2'd0: begin
        case (ch)
          2'd0:    fld_p = 5'd0;
          2'd1:    fld_p = 5'd1;
          default: fld_p = 5'd3;
        endcase
      end
      2'd1:    fld_p = {ch, 1'b0} + {3'd0, ch};
      2'd2:    fld_p = {1'b0, ch, 2'b00};
      default: fld_p = {ch, 3'b000};
    endcase
  endfunction

  // repeat a right-aligned field of width w into 8 bits, msb first
  function automatic logic [7:0] widen8(input logic [7:0] v, input logic [3:0] w);
    case (w)
      4'd1:    widen8 = {8{v[0]}};
      4'd2:    widen8 = {4{v[1:0]}};
      4'd3:    widen8 = {v[2:0], v[2:0], v[2:1]};
      4'd4:    widen8 = {2{v[3:0]}};
      default: widen8 = v;
    endcase
  endfunction

endpackage

// File: rtl/hpx_window.sv
module hpx_window
  import hpx_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int PW = PIX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [WW-1:0] word_i,
  input  mode_t         mode_i,
  input  logic          req_i,
  output logic [PW-1:0] sel_o,
  output mode_t         mode_o,
  output logic          pull_o,
  output logic          empty_o
);
  localparam int SH_W = $clog2(WW);

  logic [WW-1:0]  word_q;
  logic [SH_W-1:0] shift_q;
  mode_t          mode_q;
  logic           empty_q;
  logic [SH_W:0]  next_pos;
  logic           keep_on;
  logic [WW-1:0]  shifted;
  logic [6:0]     load_pos;

  assign pull_o   = req_i && !empty_q && !load_i;
  assign next_pos = {1'b0, shift_q} - (SH_W+1)'(pix_size(mode_q.depth));
  // double mode steps down to bit 0, otherwise only the upper half
  assign keep_on  = mode_q.dbl ? !next_pos[SH_W]
                               : (!next_pos[SH_W] && next_pos[SH_W-1:0] >= SH_W'(WW/2));
  assign load_pos = 7'(WW) - pix_size(mode_i.depth);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      shift_q <= '0;
      mode_q  <= '0;
      empty_q <= 1'b1;
    end else if (load_i) begin
      word_q  <= word_i;
      mode_q  <= mode_i;
      shift_q <= load_pos[SH_W-1:0];
      empty_q <= 1'b0;
    end else if (pull_o) begin
      if (mode_q.pk && keep_on) shift_q <= next_pos[SH_W-1:0];
      else                      empty_q <= 1'b1;
    end
  end

  assign shifted = word_q >> shift_q;
  assign sel_o   = shifted[PW-1:0] & pix_mask(mode_q.depth);
  assign mode_o  = mode_q;
  assign empty_o = empty_q;

endmodule

// File: rtl/hpx_convert.sv
module hpx_convert
  import hpx_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int NCH = CH_N
) (
  input  logic [PW-1:0] pix_i,
  input  logic [3:0]    conv_i,
  output logic [PW-1:0] pix_o
);
  logic [1:0] src_f, dst_f;
  logic       bypass;
  logic [PW-1:0] part [NCH];
  logic [PW-1:0] merged;

  always_comb begin
    bypass = 1'b0;
    src_f  = 2'd0;
    dst_f  = 2'd0;
    case (conv_i)
      4'd1:  begin src_f = 2'd0; dst_f = 2'd1; end
      4'd2:  begin src_f = 2'd0; dst_f = 2'd2; end
      4'd3:  begin src_f = 2'd0; dst_f = 2'd3; end
      4'd4:  begin src_f = 2'd1; dst_f = 2'd0; end
      4'd6:  begin src_f = 2'd1; dst_f = 2'd2; end
      4'd7:  begin src_f = 2'd1; dst_f = 2'd3; end
      4'd8:  begin src_f = 2'd2; dst_f = 2'd0; end
      4'd9:  begin src_f = 2'd2; dst_f = 2'd1; end
      4'd11: begin src_f = 2'd2; dst_f = 2'd3; end
      4'd12: begin src_f = 2'd3; dst_f = 2'd0; end
      4'd13: begin src_f = 2'd3; dst_f = 2'd1; end
      4'd14: begin src_f = 2'd3; dst_f = 2'd2; end
      default: bypass = 1'b1;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [3:0]    sw, dw;
    logic [4:0]    sp, dp;
    logic [PW-1:0] src_sh;
    logic [7:0]    raw, full, trunc;
    always_comb begin
      sw     = fld_w(src_f, 2'(c));
      sp     = fld_p(src_f, 2'(c));
      dw     = fld_w(dst_f, 2'(c));
      dp     = fld_p(dst_f, 2'(c));
      src_sh = pix_i >> sp;
      raw    = src_sh[7:0] & 8'((9'd1 << sw) - 9'd1);
      full   = widen8(raw, sw);
      trunc  = full >> (4'd8 - dw);
      part[c] = PW'(trunc) << dp;
    end
  end

  always_comb begin
    merged = '0;
    for (int c = 0; c < NCH; c++) merged = merged | part[c];
  end

  assign pix_o = bypass ? pix_i : merged;

endmodule

// File: rtl/hpx_swap.sv
module hpx_swap #(
  parameter int PW = 32
) (
  input  logic          en_i,
  input  logic [PW-1:0] pix_i,
  output logic [PW-1:0] pix_o
);
  localparam int NB = PW / 8;
  logic [PW-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev[8*b +: 8] = pix_i[8*(NB-1-b) +: 8];
  end

  assign pix_o = en_i ? rev : pix_i;

endmodule

// File: rtl/hostpix_extract.sv
module hostpix_extract
  import hpx_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int PW = PIX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [WW-1:0] word_i,
  input  logic [1:0]    depth_i,
  input  logic          packed_i,
  input  logic          dbl_i,
  input  logic [3:0]    conv_i,
  input  logic          swap_i,
  input  logic          req_i,
  output logic [PW-1:0] pix_o,
  output logic          pix_valid_o,
  output logic          empty_o
);
  mode_t         mode_in, mode_cur;
  logic [PW-1:0] sel_pix, conv_pix, final_pix;
  logic          pull;

  assign mode_in = '{depth: depth_i, pk: packed_i, dbl: dbl_i, conv: conv_i, swap: swap_i};

  hpx_window #(.WW(WW), .PW(PW)) u_win (
    .clk(clk), .rst(rst), .load_i(load_i), .word_i(word_i), .mode_i(mode_in),
    .req_i(req_i), .sel_o(sel_pix), .mode_o(mode_cur), .pull_o(pull), .empty_o(empty_o)
  );

  hpx_convert #(.PW(PW)) u_conv (
    .pix_i(sel_pix), .conv_i(mode_cur.conv), .pix_o(conv_pix)
  );

  hpx_swap #(.PW(PW)) u_swap (
    .en_i(mode_cur.swap), .pix_i(conv_pix), .pix_o(final_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o       <= '0;
      pix_valid_o <= 1'b0;
    end else begin
      pix_valid_o <= pull;
      if (pull) pix_o <= final_pix;
    end
  end

endmodule

// File: rtl/hostpix_extract_chk.sv
module hostpix_extract_chk #(
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          load_i,
  input logic          req_i,
  input logic [PW-1:0] pix_o,
  input logic          pix_valid_o,
  input logic          empty_o
);
  logic accept;
  assign accept = req_i && !empty_o && !load_i;

  // R2: a load leaves a fresh word behind
  p_load_fills_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !empty_o);

  // R7: an accepted request gives a pixel one cycle later
  p_pull_gives_pixel_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> pix_valid_o);

  // R7: no pixel and held output without an accepted request
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!pix_valid_o && $stable(pix_o)));

  // R8: an empty block stays empty until loaded
  p_empty_stays_r8: assert property (@(posedge clk) disable iff (rst)
    (empty_o && !load_i) |=> empty_o);

  // R1: reset state
  always @(posedge clk) begin
    if ($past(rst)) begin
      a_reset_state_r1: assert (empty_o && !pix_valid_o && pix_o == '0);
    end
  end

endmodule

bind hostpix_extract hostpix_extract_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .req_i(req_i),
  .pix_o(pix_o), .pix_valid_o(pix_valid_o), .empty_o(empty_o)
);

// File: tb/hostpix_extract_test.sv
module hostpix_extract_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        load = 0;
  logic [63:0] word = '0;
  logic [1:0]  depth = '0;
  logic        pk = 0, dbl = 0, swp = 0, req = 0;
  logic [3:0]  conv = '0;
  logic [31:0] pix;
  logic        pix_valid, empty;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hostpix_extract uut (
    .clk(clk), .rst(rst), .load_i(load), .word_i(word), .depth_i(depth),
    .packed_i(pk), .dbl_i(dbl), .conv_i(conv), .swap_i(swp), .req_i(req),
    .pix_o(pix), .pix_valid_o(pix_valid), .empty_o(empty)
  );

  // ---------------- behavioural reference ----------------
  int  wtab [4][3] = '{'{1,2,1}, '{3,3,2}, '{4,4,4}, '{8,8,8}};
  int  sizes [4] = '{4, 8, 12, 32};

  logic [63:0] m_word;
  int          m_shift, m_depth, m_conv;
  bit          m_pk, m_dbl, m_swap, m_empty = 1, m_valid = 0;
  logic [31:0] m_pix = '0;

  function automatic logic [31:0] ref_conv(int code, logic [31:0] p);
    int s = code / 4, d = code % 4, ps = 0, pd = 0;
    logic [31:0] r = '0;
    if (s == d) return p;
    for (int ch = 0; ch < 3; ch++) begin
      int ws = wtab[s][ch], wd = wtab[d][ch];
      logic [31:0] v = (p >> ps) & ((32'd1 << ws) - 1);
      for (int i = 0; i < wd; i++)
        r[pd + wd - 1 - i] = v[ws - 1 - (i % ws)];
      ps += ws;
      pd += wd;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_pixel(logic [63:0] w, int sh, int d, int c, bit sw);
    logic [63:0] t = w >> sh;
    logic [31:0] p = (d == 3) ? t[31:0] : (t[31:0] & ((32'd1 << sizes[d]) - 1));
    p = ref_conv(c, p);
    if (sw) p = {p[7:0], p[15:8], p[23:16], p[31:24]};
    return p;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_empty = 1; m_valid = 0; m_pix = '0;
    end else if (load) begin
      m_word = word; m_depth = depth; m_pk = pk; m_dbl = dbl; m_conv = conv; m_swap = swp;
      m_shift = 64 - sizes[depth]; m_empty = 0; m_valid = 0;
    end else if (req && !m_empty) begin
      int nx;
      m_valid = 1;
      m_pix = ref_pixel(m_word, m_shift, m_depth, m_conv, m_swap);
      nx = m_shift - sizes[m_depth];
      if (!m_pk) m_empty = 1;
      else if (m_dbl ? (nx >= 0) : (nx >= 32)) m_shift = nx;
      else m_empty = 1;
    end else begin
      m_valid = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("valid", 32'(pix_valid), 32'(m_valid));
    chk("empty", 32'(empty), 32'(m_empty));
    chk("pixel", pix, m_pix);
  endtask

  task automatic load_word(logic [63:0] w, int d, bit p, bit db, int c, bit s);
    load = 1; word = w; depth = 2'(d); pk = p; dbl = db; conv = 4'(c); swp = s;
    cyc();
    load = 0; word = '0; conv = '0; swp = 0; pk = 0; dbl = 0; depth = '0;
  endtask

  task automatic drain(output int n);
    n = 0;
    while (!empty && n < 40) begin
      req = 1; cyc(); req = 0;
      if (pix_valid) n++;
    end
  endtask

  localparam logic [63:0] PAT_A = 64'hA5C3_1E7B_96F0_2D48;
  localparam logic [63:0] PAT_B = 64'h3C96_E1D2_7A0F_84B5;

  initial begin
    int n;
    int cnt_nd [4] = '{8, 4, 2, 1};
    int cnt_db [4] = '{16, 8, 5, 2};
    logic [63:0] pats [4] = '{PAT_A, PAT_B, 64'hFFFF_FFFF_0000_0001, 64'h8421_1248_F0E1_D2C3};

    cur_req = "R1";
    rst = 1; cyc(); cyc();
    rst = 0; cyc();
    chk("reset empty R1", 32'(empty), 32'd1);

    // R3/R4: non-packed word per depth
    for (int d = 0; d < 4; d++) begin
      cur_req = "R3";
      load_word(PAT_A, d, 0, 0, 0, 0);
      req = 1; cyc(); req = 0;
      chk("first pixel R3", pix, ref_pixel(PAT_A, 64 - sizes[d], d, 0, 0));
      cur_req = "R4";
      chk("empty after one R4", 32'(empty), 32'd1);
      cur_req = "R8";
      req = 1; cyc(); cyc(); req = 0;
      chk("no pixel while empty R8", 32'(pix_valid), 32'd0);
    end

    // R5 / R6 pixel counts per depth
    for (int d = 0; d < 4; d++) begin
      cur_req = "R5";
      load_word(PAT_B, d, 1, 0, 0, 0);
      drain(n);
      chk("packed count R5", 32'(n), 32'(cnt_nd[d]));
      cur_req = "R6";
      load_word(PAT_A, d, 1, 1, 0, 0);
      drain(n);
      chk("double count R6", 32'(n), 32'(cnt_db[d]));
    end

    // R7: gaps between requests hold the pixel
    cur_req = "R7";
    load_word(PAT_B, 1, 1, 1, 0, 0);
    for (int k = 0; k < 6; k++) begin
      req = 1; cyc(); req = 0; cyc(); cyc();
    end

    // R9 / R10: every conversion code, source depth matching
    for (int c = 0; c < 16; c++) begin
      cur_req = (c % 5 == 0) ? "R10" : "R9";
      for (int j = 0; j < 4; j++) begin
        load_word(pats[j], c / 4, 1, 1, c, 0);
        req = 1; cyc(); cyc(); req = 0;
      end
    end

    // R11: swap after conversion
    cur_req = "R11";
    for (int c = 0; c < 16; c++) begin
      load_word(PAT_A, c / 4, 0, 0, c, 1);
      req = 1; cyc(); req = 0;
      chk("swapped R11", pix, ref_pixel(PAT_A, 64 - sizes[c / 4], c / 4, c, 1));
    end

    // R2: reload mid-word restarts, request with load dropped
    cur_req = "R2";
    load_word(PAT_A, 0, 1, 0, 0, 0);
    req = 1; cyc(); cyc(); cyc(); req = 0;
    req = 1;
    load_word(PAT_B, 0, 1, 0, 0, 0);
    chk("no pixel on load cycle R2", 32'(pix_valid), 32'd0);
    cyc();
    chk("restart pixel R2", pix, 32'h3);
    req = 0;
    drain(n);
    chk("full count after reload R2", 32'(n), 32'd7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule